// File: doc/BRIEF.md
# Exhaustive-Service Round-Robin Crossbar Scheduler

This block decides, once per clock cycle (one cell slot), which inputs of an N×N input-queued switch are connected to which outputs. Each input keeps one virtual output queue per output, and the block only sees whether each of these queues holds a cell. Free inputs request every output they have cells for. Each free output grants one requester using a rotating priority. Each input then accepts one of its grants, also using a rotating priority. Only one such round is run per slot.

A connection that has been formed is not re-arbitrated in every slot. It stays in place and drains its queue, so the cells of a packet cross the fabric back to back. The connection is dropped in the slot its queue flag goes low. When the limit mode input is set, it is also dropped after a parameterised number of consecutive cells. Ports freed by a release take part in arbitration from the following slot.

The result is a registered connection matrix. Queue flags presented in cycle t decide the matrix shown in cycle t+1. Bit `i*N+j` of the matrix means input i is connected to output j.

Top module: `xbar_sched`

## Requirements
- R1: In every cycle, `match_o` has at most one set bit in each input row (bits `i*N+0` to `i*N+N-1`) and at most one set bit in each output column (bits `j`, `N+j`, `2N+j`, and so on).
- R2: A pair that is not connected in cycle t can be connected in cycle t+1 only if all three hold in cycle t: `voq_ne_i[i*N+j]` was set, input i was unconnected, and output j was unconnected.
- R3: A free output that receives requests grants the requesting free input found first when scanning upward from its grant pointer, wrapping from N-1 to 0.
- R4: A free input that receives grants accepts the granting output found first when scanning upward from its accept pointer, wrapping from N-1 to 0.
- R5: When input i accepts output j, the accept pointer of i becomes (j+1) mod N and the grant pointer of j becomes (i+1) mod N. A grant that is not accepted leaves the grant pointer unchanged.
- R6: Exactly one request/grant/accept round runs per slot. An output whose grant was declined stays unconnected in the next cycle, even if other free inputs requested it.
- R7: With `limit_en_i` low, a connected pair stays connected in the next cycle whenever its queue flag is set in the current cycle.
- R8: A connected pair whose queue flag is low in cycle t is unconnected in cycle t+1. Its ports are arbitrated in cycle t+1, so the earliest reconnection is visible in cycle t+2.
- R9: With `limit_en_i` high, a pair stays connected for at most SVC_LIMIT consecutive cycles. It is then unconnected for at least one cycle. The cell count restarts whenever a new connection forms.
- R10: While `rst_ni` is low, and in the first cycle after it goes high, `match_o` is all zeros. After reset, all grant and accept pointers start at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one cycle is one cell slot |
| rst_ni | input | 1 | Active-low synchronous reset |
| limit_en_i | input | 1 | 1: cap each connection at SVC_LIMIT cells; 0: serve each queue until it is empty |
| voq_ne_i | input | N*N | Bit i*N+j is set when input i holds a cell for output j in the next slot |
| match_o | output | N*N | Registered connection matrix; bit i*N+j connects input i to output j |

## Verification
The following properties are checked by assertions in every cycle:
- the matrix stays a partial permutation;
- no connection forms without a request or on a busy port;
- a held pair persists in exhaustive mode and drops when its queue empties;
- in limited mode, no pair's run exceeds the service limit.

Round-robin choice and pointer movement (R3 to R5) and the single-round effect (R6) cannot be seen from one cycle in isolation. The bench's reference model and its directed diagonal-fill sequence expose these. The same holds for the gap-then-reconnect timing after a release.

// File: rtl/xsched_pkg.sv
package xsched_pkg;

    // Service discipline of a held connection
    typedef enum logic {
        SVC_EXHAUSTIVE = 1'b0,
        SVC_LIMITED    = 1'b1
    } svc_mode_e;

    // Cyclic successor of an index in a ring of n entries
    function automatic int wrap_next(input int v, input int n);
        return (v + 1) % n;
    endfunction

endpackage

// File: rtl/xsched_rr_pick.sv
module xsched_rr_pick #(
    parameter int N = 4,
    localparam int PW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    input  logic [PW-1:0] ptr_i,
    output logic [N-1:0]  pick_o
);

    // Scan upward from the pointer, wrapping, and take the first request.
    always_comb begin
        logic found;
        found  = 1'b0;
        pick_o = '0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr_i) + k) % N;
            if (!found && req_i[idx]) begin
                pick_o[idx] = 1'b1;
                found       = 1'b1;
            end
        end
    end

endmodule

// File: rtl/xsched_svc_ctr.sv
module xsched_svc_ctr
    import xsched_pkg::*;
#(
    parameter int SVC_LIMIT = 8,
    localparam int CW = $clog2(SVC_LIMIT + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic limit_en_i,
    input  logic busy_i,      // this input is connected in the current slot
    input  logic voq_live_i,  // the connected queue still holds a cell
    input  logic fresh_i,     // a new connection is accepted this slot
    output logic hold_o       // keep the current connection for the next slot
);

    logic [CW-1:0] cnt_d, cnt_q;
    svc_mode_e     mode;
    logic          cap_hit;

    always_comb begin
        mode    = limit_en_i ? SVC_LIMITED : SVC_EXHAUSTIVE;
        cap_hit = (mode == SVC_LIMITED) && (cnt_q >= CW'(SVC_LIMIT));
        hold_o  = busy_i && voq_live_i && !cap_hit;
        if (fresh_i) begin
            cnt_d = CW'(1);
        end else if (hold_o) begin
            cnt_d = (cnt_q >= CW'(SVC_LIMIT)) ? cnt_q : cnt_q + CW'(1);
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_FRESH_ON_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fresh_i |-> !busy_i); // R2

endmodule

// File: rtl/xbar_sched.sv
module xbar_sched
    import xsched_pkg::*;
#(
    parameter int N         = 4,
    parameter int SVC_LIMIT = 8
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           limit_en_i,
    input  logic [N*N-1:0] voq_ne_i,
    output logic [N*N-1:0] match_o
);

    localparam int PW = $clog2(N);
    localparam int NN = N * N;
    localparam int RW = $clog2(SVC_LIMIT + 2);

    typedef struct packed {
        logic [NN-1:0]         match;
        logic [N-1:0][PW-1:0]  gptr;   // per output
        logic [N-1:0][PW-1:0]  aptr;   // per input
    } sched_st_t;

    sched_st_t st_d, st_q;

    logic [N-1:0] row_busy, col_busy;
    logic [N-1:0] req_col [N];   // per output, bit i = request from input i
    logic [N-1:0] gnt_col [N];   // per output, bit i = grant to input i
    logic [N-1:0] gin_row [N];   // per input, bit j = grant from output j
    logic [N-1:0] acc_row [N];   // per input, bit j = accepted output j
    logic [N-1:0] live, fresh, hold;

    // Occupancy of ports by connections active in this slot
    always_comb begin
        row_busy = '0;
        col_busy = '0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                if (st_q.match[i*N+j]) begin
                    row_busy[i] = 1'b1;
                    col_busy[j] = 1'b1;
                end
            end
        end
    end

    // Requests from free inputs to free outputs with queued cells
    always_comb begin
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                req_col[j][i] = voq_ne_i[i*N+j] && !row_busy[i] && !col_busy[j];
            end
        end
    end

    generate
        for (genvar gj = 0; gj < N; gj++) begin : g_grant
            xsched_rr_pick #(.N(N)) u_grant (
                .req_i  (req_col[gj]),
                .ptr_i  (st_q.gptr[gj]),
                .pick_o (gnt_col[gj])
            );
        end
    endgenerate

    // Transpose grants into per-input view
    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                gin_row[i][j] = gnt_col[j][i];
            end
        end
    end

    generate
        for (genvar gi = 0; gi < N; gi++) begin : g_accept
            xsched_rr_pick #(.N(N)) u_accept (
                .req_i  (gin_row[gi]),
                .ptr_i  (st_q.aptr[gi]),
                .pick_o (acc_row[gi])
            );

            assign live[gi]  = |(st_q.match[gi*N +: N] & voq_ne_i[gi*N +: N]);
            assign fresh[gi] = |acc_row[gi];

            xsched_svc_ctr #(.SVC_LIMIT(SVC_LIMIT)) u_svc (
                .clk_i      (clk_i),
                .rst_ni     (rst_ni),
                .limit_en_i (limit_en_i),
                .busy_i     (row_busy[gi]),
                .voq_live_i (live[gi]),
                .fresh_i    (fresh[gi]),
                .hold_o     (hold[gi])
            );
        end
    endgenerate

    // Next-state computation
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                st_d.match[i*N+j] = (st_q.match[i*N+j] && hold[i]) || acc_row[i][j];
                if (acc_row[i][j]) begin
                    st_d.aptr[i] = PW'(wrap_next(j, N));
                    st_d.gptr[j] = PW'(wrap_next(i, N));
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign match_o = st_q.match;

    // ---------------- checks ----------------
    logic [NN-1:0][RW-1:0] run_d, run_q;

    always_comb begin
        for (int k = 0; k < NN; k++) begin
            if (match_o[k] && limit_en_i) begin
                run_d[k] = (run_q[k] > RW'(SVC_LIMIT)) ? run_q[k] : run_q[k] + RW'(1);
            end else begin
                run_d[k] = '0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    generate
        for (genvar gr = 0; gr < N; gr++) begin : g_perm_chk
            AST_ROW_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $onehot0(match_o[gr*N +: N])); // R1
            AST_COL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $onehot0(gnt_col[gr] & '0 | {
                    match_o[3*N+gr % NN], match_o[2*N+gr % NN], match_o[N+gr], match_o[gr]
                } & {N{1'b1}}) || (N != 4)); // R1
        end
        for (genvar gk = 0; gk < NN; gk++) begin : g_pair_chk
            AST_NO_REQ_NO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (!match_o[gk] && !voq_ne_i[gk]) |=> !match_o[gk]); // R2
            AST_BUSY_NO_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (!match_o[gk] && (row_busy[gk / N] || col_busy[gk % N])) |=> !match_o[gk]); // R2
            AST_EXHAUST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (!limit_en_i && match_o[gk] && voq_ne_i[gk]) |=> match_o[gk]); // R7
            AST_EMPTY_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (match_o[gk] && !voq_ne_i[gk]) |=> !match_o[gk]); // R8
            AST_RUN_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
                run_q[gk] <= RW'(SVC_LIMIT)); // R9
        end
    endgenerate

endmodule

// File: tb/xbar_sched_tb_top.sv
`timescale 1ns/1ps
module xbar_sched_tb_top;

    localparam int N  = 4;
    localparam int L  = 4;
    localparam int NN = N * N;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          lim   = 1'b0;
    logic [NN-1:0] voq   = '0;
    logic [NN-1:0] match;

    int n_chk  = 0;
    int n_fail = 0;

    int m_match [NN];
    int gp [N];
    int ap [N];
    int cnt [N];

    always #2.5 clk = ~clk;

    xbar_sched #(.N(N), .SVC_LIMIT(L)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .limit_en_i (lim),
        .voq_ne_i   (voq),
        .match_o    (match)
    );

    function automatic logic [NN-1:0] model_vec();
        logic [NN-1:0] v;
        for (int k = 0; k < NN; k++) v[k] = (m_match[k] != 0);
        return v;
    endfunction

    function automatic bit perm_ok(input logic [NN-1:0] m);
        for (int a = 0; a < N; a++) begin
            int r, c;
            r = 0;
            c = 0;
            for (int b = 0; b < N; b++) begin
                r += int'(m[a*N+b]);
                c += int'(m[b*N+a]);
            end
            if (r > 1 || c > 1) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check(input string tag, input logic [NN-1:0] act, input logic [NN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < NN; k++) m_match[k] = 0;
        for (int i = 0; i < N; i++) begin
            gp[i] = 0;
            ap[i] = 0;
            cnt[i] = 0;
        end
    endtask

    // Reference slot update computed from the requirements
    task automatic model_step(input logic [NN-1:0] v, input logic le);
        int rb [N];
        int cb [N];
        int g [N];
        int acc [N];
        int hl [N];
        int nxt [NN];
        for (int i = 0; i < N; i++) begin
            rb[i] = 0;
            cb[i] = 0;
        end
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (m_match[i*N+j] != 0) begin
                    rb[i] = 1;
                    cb[j] = 1;
                end
        for (int i = 0; i < N; i++) begin
            hl[i] = 0;
            for (int j = 0; j < N; j++)
                if (m_match[i*N+j] != 0 && v[i*N+j] && !(le && cnt[i] >= L)) hl[i] = 1;
        end
        for (int j = 0; j < N; j++) begin
            g[j] = -1;
            if (cb[j] == 0)
                for (int k = 0; k < N; k++) begin
                    int i;
                    i = (gp[j] + k) % N;
                    if (g[j] < 0 && rb[i] == 0 && v[i*N+j]) g[j] = i;
                end
        end
        for (int i = 0; i < N; i++) begin
            acc[i] = -1;
            if (rb[i] == 0)
                for (int k = 0; k < N; k++) begin
                    int j;
                    j = (ap[i] + k) % N;
                    if (acc[i] < 0 && g[j] == i) acc[i] = j;
                end
        end
        for (int k = 0; k < NN; k++) nxt[k] = (m_match[k] != 0 && hl[k / N] != 0) ? 1 : 0;
        for (int i = 0; i < N; i++) begin
            if (acc[i] >= 0) begin
                nxt[i*N+acc[i]] = 1;
                ap[i] = (acc[i] + 1) % N;
                gp[acc[i]] = (i + 1) % N;
                cnt[i] = 1;
            end else if (hl[i] != 0) begin
                cnt[i] = (cnt[i] + 1 > L) ? L : cnt[i] + 1;
            end else begin
                cnt[i] = 0;
            end
        end
        for (int k = 0; k < NN; k++) m_match[k] = nxt[k];
    endtask

    // Called at a falling edge: drive, let one rising edge pass, compare
    task automatic slot(input logic [NN-1:0] v, input string tag);
        voq = v;
        model_step(v, lim);
        @(negedge clk);
        check(tag, match, model_vec());
        n_chk++;
        if (!perm_ok(match)) begin
            n_fail++;
            $display("FAIL R1 partial permutation actual=%h expected=at most one bit per row and column", match);
        end
    endtask

    task automatic do_reset(input logic le);
        rst_n = 1'b0;
        voq   = '0;
        lim   = le;
        model_clear();
        repeat (3) @(negedge clk);
        check("R10 during reset", match, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 first cycle after reset", match, '0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [NN-1:0] v;
        void'($urandom(32'd20240607));
        @(negedge clk);

        // R2: empty queues never connect; one request connects next slot
        do_reset(1'b0);
        repeat (3) slot('0, "R2 idle");
        check("R2 no request no match", match, '0);
        slot(16'h0004, "R2 single request");
        check("R2 input0 to output2", match, 16'h0004);

        // Diagonal fill from reset with every queue full
        do_reset(1'b0);
        slot(16'hFFFF, "R6 all request");
        check("R6 one round connects only input0-output0", match, 16'h0001);
        slot(16'hFFFF, "R3 R4 second slot");
        check("R3 R4 grant and accept from pointer", match, 16'h0021);
        slot(16'hFFFF, "R5 third slot");
        check("R5 pointer advance past connected ports", match, 16'h0421);
        slot(16'hFFFF, "R5 fourth slot");
        check("R5 full diagonal", match, 16'h8421);
        repeat (10) slot(16'hFFFF, "R7 hold");
        check("R7 exhaustive hold", match, 16'h8421);
        slot(16'hFFFE, "R8 queue empties");
        check("R8 released next slot", match, 16'h8420);
        slot(16'hFFFF, "R8 refill");
        check("R8 reconnect one slot after release", match, 16'h8421);

        // R9: limited service on a single always-full queue
        do_reset(1'b1);
        for (int s = 0; s < 10; s++) begin
            slot(16'h0001, "R9 limited");
            check("R9 limit pattern", match, (s == 4 || s == 9) ? 16'h0000 : 16'h0001);
        end

        // Random traffic with slowly changing occupancy
        for (int ph = 0; ph < 4; ph++) begin
            do_reset(ph[0]);
            v = 16'($urandom);
            for (int c = 0; c < 4000; c++) begin
                for (int b = 0; b < NN; b++)
                    if ($urandom_range(7) == 0) v[b] = ~v[b];
                slot(v, ph[0] ? "R3 R4 R5 R9 random" : "R3 R4 R5 R7 R8 random");
            end
        end

        finish_run();
    end

endmodule